// File: doc/BRIEF.md
# Capture/Compare Timer Unit

This block is a timer for a small controller. A 16-bit up-counter is shared by three channels. The counter runs from zero up to a programmable period value, returns to zero and raises an overflow flag. This gives software a regular periodic event without any polling. A prescaler stretches each count step to 1, 2, 4 or 8 clock cycles so that longer intervals can be measured. The counter can be started by software, or it can be armed so that an edge on an external start pin sets it running.

Each channel works in one of two modes. In capture mode, the channel records the counter value when its input pin shows the selected edge, so the edge can be handled later with an exact time stamp. In compare mode, the channel drives its output pin high when the counter wraps and low when the counter reaches the channel value. This gives a PWM waveform, or a single scheduled output event, with no software action at that moment.

Every event sets a sticky flag. Software clears a flag by writing 1 to it. The interrupt request is the OR of every flag whose enable bit is set. Software reaches all state through a word-addressed register port. Writes are registered, and reads are combinational from the current address.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the counter is 0, all flags, enables, channel settings and channel values are 0, the control word is 0, the period register is 0xFFFF, every compare output is low and irq is low.
- R2: While the counter runs, each count step at which the count is greater than or equal to the period register loads 0 and sets the overflow flag (flag bit 0). Any other count step adds 1. One full period therefore takes period+1 steps.
- R3: Control bits [3:2] select the prescaler: 0, 1, 2 and 3 give one count step every 1, 2, 4 and 8 clock cycles.
- R4: When control bit 0 (run) is 0, the count holds its value. A write to the control register with bit 4 set loads 0 into the count and restarts the prescaler.
- R5: When control bit 1 (arm) is 1, a rising edge on extStart sets the run bit. While arm is 0, extStart has no effect.
- R6: Channel configuration bit 0 = 1 selects capture mode. Configuration bit 1 selects the edge: 0 for rising, 1 for falling. On the selected edge of capIn (passed through a two-stage synchronizer), the channel value register loads the current count and sets channel flag bit 1+ch. The other edge is ignored.
- R7: In compare mode (configuration bit 0 = 0), the channel output goes high at a wrap step. It goes low at the step where the new count equals the channel value, and this low takes priority. That step also sets flag bit 1+ch. A value of 0 keeps the output low. A value above the period keeps it high. A value v between these makes the output high for v of every period+1 steps.
- R8: Flags are sticky. Writing 1 to a bit of the flag register clears that bit. Writing 0 leaves it unchanged.
- R9: irq is high exactly when some flag bit and its enable bit in the enable register are both 1.
- R10: Word addresses: 0 control, 1 period, 2 count (read only), 3 flags, 4 interrupt enable, 5 to 7 channel 0 to 2 configuration, 8 to 10 channel 0 to 2 values. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regAddr |
| extStart | input | 1 | External start pin |
| capIn | input | 3 | Capture input pins, one per channel |
| cmpOut | output | 3 | Compare/PWM output pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The compare path is driven with PWM settings that combine different channel values and prescaler ratios. The counted high and low run lengths separate errors in the wrap point, in the match point and in the prescaler divisor, because each of these changes a different length. The two extreme channel values, zero and above the period, show whether match takes priority over set at the wrap. Capture is driven first with the edge that is not selected and then with the selected edge while the counter is frozen. This separates edge-select errors from errors in the captured value. External start is tried once with arm cleared and once with arm set.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int CNT_W  = 16;
  localparam int NCH    = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int PRE_W  = 3;
  localparam int FLAG_W = NCH + 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CFG0   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CCV0   = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic              clearCnt;
    logic [NCH-1:0]    capStb;
    logic [NCH-1:0]    ccWr;
    logic [CNT_W-1:0]  wrData;
  } tmrStrobe_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  input  logic                         extStart,
  input  logic [NCH-1:0]               capIn,
  input  logic [CNT_W-1:0]             count,
  input  logic [NCH-1:0][CNT_W-1:0]    ccVal,
  input  logic                         wrapEv,
  input  logic [NCH-1:0]               matchEv,
  output tmrStrobe_t                   strobe,
  output logic [CNT_W-1:0]             period,
  output logic [NCH-1:0]               capMode,
  output logic [FLAG_W-1:0]            flags,
  output logic [FLAG_W-1:0]            ien,
  output logic                         irq
);
  logic runBit, armBit;
  logic [1:0] preSel;
  logic [PRE_W-1:0] preCnt, preMask;
  logic [NCH-1:0][1:0] cfg;
  logic wrCtrl, wrPeriod, wrFlags, wrIen;
  logic clearReq;
  logic extS1, extS2, extPrev, extRise;
  logic [NCH-1:0] capS1, capS2, capPrev, capRise, capFall, capHit;
  logic [FLAG_W-1:0] setVec, clrMask;

  assign wrCtrl   = regWr && (regAddr == ADR_CTRL);
  assign wrPeriod = regWr && (regAddr == ADR_PERIOD);
  assign wrFlags  = regWr && (regAddr == ADR_FLAGS);
  assign wrIen    = regWr && (regAddr == ADR_IEN);
  assign clearReq = wrCtrl && regWdata[4];

  // control word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit <= 1'b0;
      armBit <= 1'b0;
      preSel <= 2'd0;
    end else if (wrCtrl) begin
      runBit <= regWdata[0];
      armBit <= regWdata[1];
      preSel <= regWdata[3:2];
    end else if (armBit && extRise) begin
      runBit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= '1;
      ien    <= '0;
    end else begin
      if (wrPeriod) period <= regWdata[CNT_W-1:0];
      if (wrIen)    ien    <= regWdata[FLAG_W-1:0];
    end
  end

  // external start synchronizer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extS1 <= 1'b0; extS2 <= 1'b0; extPrev <= 1'b0;
    end else begin
      extS1 <= extStart; extS2 <= extS1; extPrev <= extS2;
    end
  end
  assign extRise = extS2 && !extPrev;

  // prescaler
  always_comb begin
    case (preSel)
      2'd0:    preMask = 3'b000;
      2'd1:    preMask = 3'b001;
      2'd2:    preMask = 3'b011;
      default: preMask = 3'b111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearReq) preCnt <= '0;
    else if (runBit)       preCnt <= preCnt + 1'b1;
  end

  // per-channel configuration and capture detection
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chan
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfg[i] <= 2'b00;
        end else if (regWr && (regAddr == ADDR_W'(ADR_CFG0 + i))) begin
          cfg[i] <= regWdata[1:0];
        end
      end
      always_ff @(posedge clk) begin
        if (!rstN) begin
          capS1[i] <= 1'b0; capS2[i] <= 1'b0; capPrev[i] <= 1'b0;
        end else begin
          capS1[i] <= capIn[i]; capS2[i] <= capS1[i]; capPrev[i] <= capS2[i];
        end
      end
      assign capRise[i] = capS2[i] && !capPrev[i];
      assign capFall[i] = !capS2[i] && capPrev[i];
      assign capHit[i]  = cfg[i][0] && (cfg[i][1] ? capFall[i] : capRise[i]);
      assign capMode[i] = cfg[i][0];
      assign strobe.ccWr[i] = regWr && (regAddr == ADDR_W'(ADR_CCV0 + i));
    end
  endgenerate

  assign strobe.tick     = runBit && !clearReq && ((preCnt & preMask) == preMask);
  assign strobe.clearCnt = clearReq;
  assign strobe.capStb   = capHit;
  assign strobe.wrData   = regWdata[CNT_W-1:0];

  // flags
  assign setVec  = {capHit | matchEv, wrapEv};
  assign clrMask = wrFlags ? regWdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | setVec;
  end

  assign irq = |(flags & ien);

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADR_CTRL: begin
        regRdata[0]   = runBit;
        regRdata[1]   = armBit;
        regRdata[3:2] = preSel;
      end
      ADR_PERIOD: regRdata[CNT_W-1:0]  = period;
      ADR_COUNT:  regRdata[CNT_W-1:0]  = count;
      ADR_FLAGS:  regRdata[FLAG_W-1:0] = flags;
      ADR_IEN:    regRdata[FLAG_W-1:0] = ien;
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (regAddr == ADDR_W'(ADR_CFG0 + i)) regRdata[1:0] = cfg[i];
          if (regAddr == ADDR_W'(ADR_CCV0 + i)) regRdata[CNT_W-1:0] = ccVal[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/capcmp_dpath.sv
module capcmp_dpath
  import capcmp_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  tmrStrobe_t                   strobe,
  input  logic [CNT_W-1:0]             period,
  input  logic [NCH-1:0]               capMode,
  output logic [CNT_W-1:0]             count,
  output logic [NCH-1:0][CNT_W-1:0]    ccVal,
  output logic [NCH-1:0]               cmpOut,
  output logic                         wrapEv,
  output logic [NCH-1:0]               matchEv
);
  logic [CNT_W-1:0] nextCnt;

  assign wrapEv  = strobe.tick && (count >= period);
  assign nextCnt = wrapEv ? '0 : count + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearCnt) count <= '0;
    else if (strobe.tick)         count <= nextCnt;
  end

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign matchEv[i] = !capMode[i] && strobe.tick && (nextCnt == ccVal[i]);

      always_ff @(posedge clk) begin
        if (!rstN)                   ccVal[i] <= '0;
        else if (strobe.capStb[i])   ccVal[i] <= count;
        else if (strobe.ccWr[i])     ccVal[i] <= strobe.wrData;
      end

      always_ff @(posedge clk) begin
        if (!rstN || capMode[i]) cmpOut[i] <= 1'b0;
        else if (matchEv[i])     cmpOut[i] <= 1'b0;
        else if (wrapEv)         cmpOut[i] <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              extStart,
  input  logic [2:0]        capIn,
  output logic [2:0]        cmpOut,
  output logic              irq
);
  tmrStrobe_t strobe;
  logic [CNT_W-1:0] period, count;
  logic [NCH-1:0][CNT_W-1:0] ccVal;
  logic [NCH-1:0] capMode, matchEv;
  logic wrapEv;
  logic [FLAG_W-1:0] flags, ien;

  capcmp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extStart(extStart),
    .capIn(capIn), .count(count), .ccVal(ccVal), .wrapEv(wrapEv),
    .matchEv(matchEv), .strobe(strobe), .period(period),
    .capMode(capMode), .flags(flags), .ien(ien), .irq(irq)
  );

  capcmp_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(period),
    .capMode(capMode), .count(count), .ccVal(ccVal), .cmpOut(cmpOut),
    .wrapEv(wrapEv), .matchEv(matchEv)
  );
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk
  import capcmp_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              clearCnt,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  period,
  input logic              wrapEv,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] ien,
  input logic              irq,
  input logic [NCH-1:0]    cmpOut,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata
);
  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && count >= period) |=> (count == '0));

  // R4
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !clearCnt) |=> $stable(count));

  // R4
  clear_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearCnt |=> (count == '0));

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !(regWr && regAddr == ADR_FLAGS && regWdata[0])) |=> flags[0]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ien == '0) |-> !irq);

  // R7
  set_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpOut[0]) |-> $past(wrapEv));
endmodule

bind capcmp_timer capcmp_chk u_chk (
  .clk(clk), .rstN(rstN), .tick(strobe.tick), .clearCnt(strobe.clearCnt),
  .count(count), .period(period), .wrapEv(wrapEv), .flags(flags),
  .ien(ien), .irq(irq), .cmpOut(cmpOut), .regWr(regWr),
  .regAddr(regAddr), .regWdata(regWdata)
);

// File: tb/test_capcmp_timer.sv
`timescale 1ns/1ps
module test_capcmp_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic extStart = 1'b0;
  logic [2:0] capIn = 3'b000;
  logic [2:0] cmpOut;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  capcmp_timer i_capcmp_timer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extStart(extStart),
    .capIn(capIn), .cmpOut(cmpOut), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output int d);
    @(negedge clk);
    regAddr = a;
    #1 d = int'(regRdata);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measurePwm(output int hi, output int lo);
    int g;
    g = 0; hi = 0; lo = 0;
    while (cmpOut[0] !== 1'b0 && g < 400) begin @(negedge clk); g++; end
    while (cmpOut[0] !== 1'b1 && g < 400) begin @(negedge clk); g++; end
    while (cmpOut[0] === 1'b1 && g < 400) begin @(negedge clk); g++; hi++; end
    while (cmpOut[0] === 1'b0 && g < 400) begin @(negedge clk); g++; lo++; end
  endtask

  task automatic t_reset();
    int v;
    rdReg(4'd2, v);  check("R1 count", v, 0);
    rdReg(4'd3, v);  check("R1 flags", v, 0);
    rdReg(4'd0, v);  check("R1 ctrl", v, 0);
    rdReg(4'd1, v);  check("R1 period", v, 16'hFFFF);
    rdReg(4'd9, v);  check("R1 ccval1", v, 0);
    rdReg(4'd15, v); check("R10 unused addr", v, 0);
    check("R1 cmpOut", int'(cmpOut), 0);
    check("R1 irq", int'(irq), 0);
  endtask

  task automatic t_wrap();
    int v, mx, seenZero;
    wrReg(4'd1, 16'd9);
    wrReg(4'd8, 16'd3);
    wrReg(4'd0, 16'h0001);
    mx = 0; seenZero = 0;
    for (int i = 0; i < 30; i++) begin
      rdReg(4'd2, v);
      if (v > mx) mx = v;
      if (v == 0) seenZero = 1;
    end
    check("R2 max count equals period", mx, 9);
    check("R2 wrapped to zero", seenZero, 1);
    rdReg(4'd3, v);
    check("R2 overflow flag", v & 1, 1);
    check("R7 compare flag ch0", (v >> 1) & 1, 1);
  endtask

  task automatic t_pwm(input logic [1:0] sel, input int ccv, input int expHi, input int expLo);
    int hi, lo;
    wrReg(4'd8, 16'(ccv));
    wrReg(4'd0, {12'd0, sel, 2'b01});
    measurePwm(hi, lo);
    check($sformatf("R7 R3 pwm high sel%0d cc%0d", sel, ccv), hi, expHi);
    check($sformatf("R7 R3 pwm low sel%0d cc%0d", sel, ccv), lo, expLo);
  endtask

  task automatic t_pwmEdge();
    int bad;
    wrReg(4'd0, 16'h0001);
    wrReg(4'd8, 16'd0);
    waitCyc(12);
    bad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cmpOut[0] !== 1'b0) bad++; end
    check("R7 cc zero stays low", bad, 0);
    wrReg(4'd8, 16'd20);
    waitCyc(12);
    bad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cmpOut[0] !== 1'b1) bad++; end
    check("R7 cc above period stays high", bad, 0);
  endtask

  task automatic t_hold();
    int a, b;
    wrReg(4'd0, 16'h0000);
    rdReg(4'd2, a);
    waitCyc(10);
    rdReg(4'd2, b);
    check("R4 stopped count holds", b, a);
    wrReg(4'd0, 16'h0010);
    rdReg(4'd2, b);
    check("R4 clear count", b, 0);
  endtask

  task automatic t_flags();
    int v;
    wrReg(4'd3, 16'h0000);
    rdReg(4'd3, v);
    check("R8 write zero keeps flag", v & 1, 1);
    wrReg(4'd4, 16'h0000);
    check("R9 irq masked", int'(irq), 0);
    wrReg(4'd4, 16'h0001);
    @(negedge clk);
    check("R9 irq enabled", int'(irq), 1);
    wrReg(4'd3, 16'h000F);
    rdReg(4'd3, v);
    check("R8 write one clears", v, 0);
    check("R9 irq after clear", int'(irq), 0);
    wrReg(4'd4, 16'h0000);
  endtask

  task automatic t_capture();
    int v, c;
    wrReg(4'd1, 16'd200);
    wrReg(4'd0, 16'h0001);
    waitCyc(37);
    wrReg(4'd0, 16'h0000);
    rdReg(4'd2, c);
    wrReg(4'd6, 16'h0001);
    wrReg(4'd7, 16'h0003);
    wrReg(4'd10, 16'h1234);
    wrReg(4'd3, 16'h000F);
    @(negedge clk); capIn[1] = 1'b1; capIn[2] = 1'b1;
    waitCyc(6);
    rdReg(4'd9, v);  check("R6 rising capture value", v, c);
    rdReg(4'd10, v); check("R6 rising ignored on falling channel", v, 16'h1234);
    rdReg(4'd3, v);
    check("R6 capture flag ch1", (v >> 2) & 1, 1);
    check("R6 no flag ch2 on rise", (v >> 3) & 1, 0);
    check("R6 capture channel output low", int'(cmpOut[1]), 0);
    @(negedge clk); capIn[2] = 1'b0;
    waitCyc(6);
    rdReg(4'd10, v); check("R6 falling capture value", v, c);
    rdReg(4'd3, v);  check("R6 flag ch2 on fall", (v >> 3) & 1, 1);
    capIn = 3'b000;
  endtask

  task automatic t_ext();
    int v, a;
    wrReg(4'd0, 16'h0010);
    @(negedge clk); extStart = 1'b1;
    waitCyc(4); extStart = 1'b0;
    waitCyc(4);
    rdReg(4'd0, v); check("R5 unarmed start ignored", v & 1, 0);
    wrReg(4'd0, 16'h0012);
    waitCyc(8);
    rdReg(4'd2, a); check("R5 armed waits", a, 0);
    @(negedge clk); extStart = 1'b1;
    waitCyc(4); extStart = 1'b0;
    waitCyc(6);
    rdReg(4'd0, v); check("R5 run bit set by start", v & 1, 1);
    rdReg(4'd2, a); check("R5 counter moving", int'(a > 0), 1);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    t_reset();
    t_wrap();
    t_pwm(2'd0, 3, 3, 7);
    t_pwm(2'd2, 3, 12, 28);
    t_pwm(2'd1, 6, 12, 8);
    t_pwm(2'd3, 1, 8, 72);
    t_pwmEdge();
    t_hold();
    t_flags();
    t_capture();
    t_ext();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule